// File: doc/BRIEF.md
# Addressable Scan Chain Bridge

This block sits on one board between a shared backplane IEEE 1149.1 test bus and a set of local scan chains. Several boards hang on the same backplane bus. Each bridge tracks the backplane TAP controller state. After a test-logic reset, the first instruction scan carries a board address. Only the bridge whose strapped address matches takes part in later scans. A bridge whose address does not match stays silent until the next reset.

Once addressed, the bridge takes a select instruction that turns its data register into a port-select mask. Every port whose mask bit is set is spliced into the active chain, in ascending index order, between backplane TDI and the bridge's own register. That register is the last stage before backplane TDO. A deselected port has its TMS held high, so the devices behind it stay parked in test-logic reset. Every TDO-style output carries a companion tristate indicator, which is high when the pin would float. A separate float input releases the local clock, mode-select and reset lines.

Bridges can be cascaded: a local port may feed the backplane side of another bridge. Every spliced port adds one retiming stage to the chain.

Top module: `scan_bridge`

## Requirements
- R1: While or after `bp_trst_n` is low, `bp_tri` is 1, every `lp_tri` bit is 1 and every `lp_tms` bit is 1 whatever `bp_tms` is, because the select mask is empty.
- R2: The first instruction scan after test-logic reset is the address scan. On Update-IR, the low ADDR_W bits of the shifted value are compared with `board_addr`, and a match makes the bridge addressed. The bridge never drives backplane TDO during the address scan.
- R3: A mismatch makes the bridge rejected until test-logic reset. While rejected, `bp_tri` stays 1 in every scan and select instructions have no effect on the local ports.
- R4: `bp_tri` is 0 only while the bridge is addressed and the TAP is in Shift-IR or Shift-DR. Both `bp_tri` and `bp_tdo` change only on the falling edge of `bp_tck`.
- R5: Capture-IR loads the instruction shifter with the value 1 in bit 0 and 0 in every other bit. LSB-first shift-out therefore starts 1, 0.
- R6: Instruction code 0x01 (IR_W bits) selects the N-bit select register: bit i set means port i is spliced, the register is loaded on Update-DR, and the first bit shifted in lands in bit 0. Any other code selects a 1-bit bypass register that captures 0.
- R7: Selected ports are chained in ascending index order. Each selected port's `lp_tdo` presents, from the falling edge, the value its upstream source had at the preceding rising edge. The upstream source is `bp_tdi` or the previous selected port's `lp_tdi`. The bridge register shifts in the last selected port's `lp_tdi`, or `bp_tdi` if none is selected, and feeds `bp_tdo`.
- R8: `lp_tri[i]` is 0 only while port i is selected and the TAP is in a shift state.
- R9: A deselected port's `lp_tms` is 1 and a selected port's `lp_tms` follows `bp_tms`. Every `lp_tck` follows `bp_tck` and every `lp_trst_n` follows `bp_trst_n`.
- R10: `lp_ctl_hiz` is 1 exactly when `lp_float` is 1. It marks the local clock, mode-select and reset lines as released.
- R11: Five clocks with `bp_tms` high clear the select mask and the addressed and rejected status, so the next instruction scan is again an address scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bp_tck | input | 1 | Backplane test clock |
| bp_trst_n | input | 1 | Backplane asynchronous test reset, active low |
| bp_tms | input | 1 | Backplane mode select |
| bp_tdi | input | 1 | Backplane serial data in |
| bp_tdo | output | 1 | Backplane serial data out value |
| bp_tri | output | 1 | High when backplane TDO floats |
| board_addr | input | ADDR_W | Strapped board address |
| lp_float | input | 1 | High releases local clock, mode-select and reset lines |
| lp_ctl_hiz | output | 1 | High when local control lines are released |
| lp_tck | output | N | Local test clocks |
| lp_tms | output | N | Local mode selects |
| lp_trst_n | output | N | Local test resets, active low |
| lp_tdo | output | N | Serial data toward each local chain |
| lp_tdi | input | N | Serial data returning from each local chain |
| lp_tri | output | N | High when the matching lp_tdo floats |

## Verification
On every Shift-DR clock, a bit hops through each spliced port's retiming stage, and the bridge's bypass register shifts in the returning data on the same rising edge. The bench provokes this with two non-adjacent ports selected while it varies `bp_tdi` and both returning port inputs independently in each cycle. It judges each hop at its own output after the falling edge, so a wrong port order, a skipped stage or a stale capture each shows up on a different pin.

// File: rtl/scan_bridge_pkg.sv
package scan_bridge_pkg;
    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_e;
endpackage

// File: rtl/sb_tap.sv
module sb_tap
    import scan_bridge_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output tap_e state
);
    typedef struct packed {
        tap_e st;
    } tap_t;

    tap_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        case (t_q.st)
            ST_TLR:    t_d.st = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    t_d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: t_d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: t_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  t_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: t_d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: t_d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: t_d.st = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: t_d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: t_d.st = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: t_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  t_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: t_d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: t_d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: t_d.st = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: t_d.st = tms ? ST_SEL_DR : ST_RTI;
            default:   t_d.st = ST_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) t_q <= '{st: ST_TLR};
        else         t_q <= t_d;
    end

    assign state = t_q.st;

    // Leaving reset into idle requires TMS low.
    AST_TLR_EXIT: assert property (@(posedge tck) disable iff (!trst_n)
        (t_q.st == ST_TLR && tms) |=> (t_q.st == ST_TLR)); // R11
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import scan_bridge_pkg::*;
#(
    parameter int N        = 4,
    parameter int ADDR_W   = 6,
    parameter int IR_W     = 8,
    parameter logic [IR_W-1:0] SEL_CODE = 1
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_e              state,
    input  logic              tail,
    input  logic [ADDR_W-1:0] board_addr,
    output logic              addressed,
    output logic [N-1:0]      sel,
    output logic              shifting,
    output logic              ser_out
);
    localparam logic [IR_W-1:0] BYPASS_CODE = '1;
    localparam logic [IR_W-1:0] IR_CAPTURE  = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0] ir;
        logic [IR_W-1:0] instr;
        logic [N-1:0]    dr;
        logic            byp;
        logic [N-1:0]    sel;
        logic            addressed;
        logic            rejected;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  sel_instr;

    assign sel_instr = (c_q.instr == SEL_CODE);

    always_comb begin
        c_d = c_q;
        case (state)
            ST_TLR: begin
                c_d.addressed = 1'b0;
                c_d.rejected  = 1'b0;
                c_d.sel       = '0;
                c_d.instr     = BYPASS_CODE;
            end
            ST_CAP_IR: c_d.ir = IR_CAPTURE;
            ST_SH_IR:  c_d.ir = {tail, c_q.ir[IR_W-1:1]};
            ST_UPD_IR: begin
                if (!c_q.addressed && !c_q.rejected) begin
                    if (c_q.ir[ADDR_W-1:0] == board_addr) c_d.addressed = 1'b1;
                    else                                  c_d.rejected  = 1'b1;
                end else if (c_q.addressed) begin
                    c_d.instr = c_q.ir;
                end
            end
            ST_CAP_DR: begin
                if (sel_instr) c_d.dr  = c_q.sel;
                else           c_d.byp = 1'b0;
            end
            ST_SH_DR: begin
                if (sel_instr) c_d.dr  = {tail, c_q.dr[N-1:1]};
                else           c_d.byp = tail;
            end
            ST_UPD_DR: begin
                if (c_q.addressed && sel_instr) c_d.sel = c_q.dr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) c_q <= '{ir: '0, instr: BYPASS_CODE, dr: '0, byp: 1'b0,
                              sel: '0, addressed: 1'b0, rejected: 1'b0};
        else         c_q <= c_d;
    end

    assign addressed = c_q.addressed;
    assign sel       = c_q.sel;
    assign shifting  = (state == ST_SH_IR) || (state == ST_SH_DR);
    assign ser_out   = (state == ST_SH_IR) ? c_q.ir[0]
                     : (sel_instr ? c_q.dr[0] : c_q.byp);

    AST_ROLE_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
        !(c_q.addressed && c_q.rejected)); // R3
    AST_REJECT_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
        (c_q.rejected && state != ST_TLR) |=> c_q.rejected); // R3
    AST_ADDR_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(c_q.addressed) |-> ($past(state) == ST_UPD_IR)); // R2
    AST_SEL_CLEAR: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (c_q.sel == '0)); // R11
endmodule

// File: rtl/sb_route.sv
module sb_route #(
    parameter int N = 4
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         bp_tdi,
    input  logic         bp_tms,
    input  logic [N-1:0] lp_tdi,
    input  logic [N-1:0] sel,
    input  logic         shifting,
    input  logic         addressed,
    input  logic         ser_out,
    output logic         tail,
    output logic         bp_tdo,
    output logic         bp_tri,
    output logic [N-1:0] lp_tdo,
    output logic [N-1:0] lp_tri,
    output logic [N-1:0] lp_tms
);
    typedef struct packed {
        logic         tdi;
        logic [N-1:0] lp;
    } cap_t;

    typedef struct packed {
        logic         tdo;
        logic         drv;
        logic [N-1:0] lp_tdo;
        logic [N-1:0] lp_drv;
    } out_t;

    cap_t         cap_d, cap_q;
    out_t         out_d, out_q;
    logic [N-1:0] src;

    // Rising-edge capture of every serial input.
    always_comb begin
        cap_d.tdi = bp_tdi;
        cap_d.lp  = lp_tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    // Raw chain tail into the bridge register, and retimed sources per port.
    always_comb begin
        logic t;
        logic lk;
        t  = bp_tdi;
        lk = cap_q.tdi;
        for (int i = 0; i < N; i++) begin
            src[i] = lk;
            if (sel[i]) begin
                t  = lp_tdi[i];
                lk = cap_q.lp[i];
            end
        end
        tail = t;
    end

    // Falling-edge output stage.
    always_comb begin
        out_d.tdo    = ser_out;
        out_d.drv    = shifting && addressed;
        out_d.lp_tdo = src;
        out_d.lp_drv = sel & {N{shifting}};
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign bp_tdo = out_q.tdo;
    assign bp_tri = ~out_q.drv;
    assign lp_tdo = out_q.lp_tdo;
    assign lp_tri = ~out_q.lp_drv;

    for (genvar g = 0; g < N; g++) begin : g_port
        assign lp_tms[g] = sel[g] ? bp_tms : 1'b1;

        AST_DESEL_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
            !sel[g] |-> lp_tri[g]); // R8
    end
endmodule

// File: rtl/scan_bridge.sv
module scan_bridge
    import scan_bridge_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 6,
    parameter int IR_W   = 8
) (
    input  logic              bp_tck,
    input  logic              bp_trst_n,
    input  logic              bp_tms,
    input  logic              bp_tdi,
    output logic              bp_tdo,
    output logic              bp_tri,
    input  logic [ADDR_W-1:0] board_addr,
    input  logic              lp_float,
    output logic              lp_ctl_hiz,
    output logic [N-1:0]      lp_tck,
    output logic [N-1:0]      lp_tms,
    output logic [N-1:0]      lp_trst_n,
    output logic [N-1:0]      lp_tdo,
    input  logic [N-1:0]      lp_tdi,
    output logic [N-1:0]      lp_tri
);
    localparam logic [IR_W-1:0] SEL_CODE = IR_W'(1);

    tap_e         state;
    logic         tail;
    logic         addressed;
    logic         shifting;
    logic         ser_out;
    logic [N-1:0] sel;

    sb_tap u_tap (
        .tck    (bp_tck),
        .trst_n (bp_trst_n),
        .tms    (bp_tms),
        .state  (state)
    );

    sb_ctrl #(.N(N), .ADDR_W(ADDR_W), .IR_W(IR_W), .SEL_CODE(SEL_CODE)) u_ctrl (
        .tck        (bp_tck),
        .trst_n     (bp_trst_n),
        .state      (state),
        .tail       (tail),
        .board_addr (board_addr),
        .addressed  (addressed),
        .sel        (sel),
        .shifting   (shifting),
        .ser_out    (ser_out)
    );

    sb_route #(.N(N)) u_route (
        .tck       (bp_tck),
        .trst_n    (bp_trst_n),
        .bp_tdi    (bp_tdi),
        .bp_tms    (bp_tms),
        .lp_tdi    (lp_tdi),
        .sel       (sel),
        .shifting  (shifting),
        .addressed (addressed),
        .ser_out   (ser_out),
        .tail      (tail),
        .bp_tdo    (bp_tdo),
        .bp_tri    (bp_tri),
        .lp_tdo    (lp_tdo),
        .lp_tri    (lp_tri),
        .lp_tms    (lp_tms)
    );

    assign lp_tck     = {N{bp_tck}};
    assign lp_trst_n  = {N{bp_trst_n}};
    assign lp_ctl_hiz = lp_float;

    AST_QUIET_UNADDR: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        !addressed |-> bp_tri); // R2
    AST_LOCAL_NEEDS_ADDR: assert property (@(posedge bp_tck) disable iff (!bp_trst_n)
        !addressed |-> (lp_tri == '1)); // R3
endmodule

// File: tb/scan_bridge_test.sv
`timescale 1ns/1ps
module scan_bridge_test;
    localparam int N = 4;
    localparam int ADDR_W = 6;
    localparam int IR_W = 8;
    localparam logic [ADDR_W-1:0] MY_ADDR = 6'h2A;
    localparam logic [IR_W-1:0]   SEL_OP  = 8'h01;
    localparam int ROWS = 10;
    // {bp_tdi, lp_tdi[0], lp_tdi[2], exp lp_tdo[0], exp lp_tdo[2], exp bp_tdo}
    localparam logic [5:0] VEC [ROWS] = '{
        6'b100_100, 6'b010_010, 6'b001_001, 6'b111_111, 6'b000_000,
        6'b101_101, 6'b011_011, 6'b110_110, 6'b100_100, 6'b001_001
    };

    logic bp_tck = 1'b0, bp_trst_n, bp_tms, bp_tdi, bp_tdo, bp_tri;
    logic [ADDR_W-1:0] board_addr;
    logic lp_float, lp_ctl_hiz;
    logic [N-1:0] lp_tck, lp_tms, lp_trst_n, lp_tdo, lp_tdi, lp_tri;
    int nchk = 0, nfail = 0;
    bit done = 0;

    scan_bridge #(.N(N), .ADDR_W(ADDR_W), .IR_W(IR_W)) uut (
        .bp_tck(bp_tck), .bp_trst_n(bp_trst_n), .bp_tms(bp_tms), .bp_tdi(bp_tdi),
        .bp_tdo(bp_tdo), .bp_tri(bp_tri), .board_addr(board_addr),
        .lp_float(lp_float), .lp_ctl_hiz(lp_ctl_hiz), .lp_tck(lp_tck),
        .lp_tms(lp_tms), .lp_trst_n(lp_trst_n), .lp_tdo(lp_tdo),
        .lp_tdi(lp_tdi), .lp_tri(lp_tri)
    );

    always #2.5 bp_tck = ~bp_tck;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs change 1 ns before a rising edge; outputs are read at that same point.
    task automatic step(input logic tms, input logic tdi);
        bp_tms = tms;
        bp_tdi = tdi;
        #5;
    endtask

    task automatic tms_reset();
        repeat (5) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic ir_scan(input logic [IR_W-1:0] v, output logic [IR_W-1:0] seen,
                           output logic drove);
        drove = 1'b0;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < IR_W; i++) begin
            seen[i] = bp_tdo;
            if (!bp_tri) drove = 1'b1;
            step(i == IR_W - 1, v[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic dr_scan(input logic [N-1:0] v);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < N; i++) step(i == N - 1, v[i]);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [IR_W-1:0] seen;
        logic drove;
        bp_trst_n = 1'b0; bp_tms = 1'b1; bp_tdi = 1'b0;
        lp_tdi = '0; lp_float = 1'b0; board_addr = MY_ADDR;
        @(posedge bp_tck);
        #4;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // R1: reset state with bp_tms low
        check("R1 bp_tri", bp_tri, 1);
        check("R1 lp_tri", lp_tri, 4'hF);
        check("R1 lp_tms", lp_tms, 4'hF);
        bp_trst_n = 1'b1;
        step(1'b0, 1'b0);

        // R2/R3: mismatching address, then rejected bridge ignores select
        ir_scan(8'h15, seen, drove);
        check("R2 silent address scan", drove, 0);
        ir_scan(SEL_OP, seen, drove);
        check("R3 rejected stays tristated", drove, 0);
        dr_scan(4'hF);
        check("R3 select ignored lp_tms", lp_tms, 4'hF);

        // R11 then R2: reset by TMS, match on low ADDR_W bits only
        tms_reset();
        ir_scan({2'b11, MY_ADDR}, seen, drove);
        check("R2 matching address scan silent", drove, 0);
        ir_scan(SEL_OP, seen, drove);
        check("R4 addressed drives in Shift-IR", drove, 1);
        check("R5 capture pattern", seen, 8'h01);

        // R6/R9: select ports 0 and 2
        dr_scan(4'b0101);
        check("R9 lp_tms follows only selected", lp_tms, 4'b1010);
        check("R8 idle lp_tri", lp_tri, 4'hF);
        check("R4 idle bp_tri", bp_tri, 1);

        // Bypass instruction (bridge IR fills from the chain tail, held at 0)
        ir_scan(8'h00, seen, drove);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // R7: vectors through two spliced ports and the bypass stage
        for (int r = 0; r < ROWS; r++) begin
            bp_tms = 1'b0;
            bp_tdi = VEC[r][5];
            lp_tdi = {1'b0, VEC[r][3], 1'b0, VEC[r][4]};
            #5;
            check("R7 port0 hop", lp_tdo[0], VEC[r][2]);
            check("R7 port2 hop", lp_tdo[2], VEC[r][1]);
            check("R7 bridge register last", bp_tdo, VEC[r][0]);
            check("R8 shift lp_tri", lp_tri, 4'b1010);
            check("R4 shift bp_tri", bp_tri, 0);
        end
        lp_tdi = '0;
        step(1'b1, 1'b0);
        check("R4 exit bp_tri", bp_tri, 1);
        check("R8 exit lp_tri", lp_tri, 4'hF);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check("R6 bypass kept selection", lp_tms, 4'b1010);

        // R11: five TMS-high clocks clear selection and addressing
        tms_reset();
        check("R11 selection cleared", lp_tms, 4'hF);
        ir_scan(SEL_OP, seen, drove);
        check("R11 address scan again silent", drove, 0);

        // R1: asynchronous reset clears a live selection
        bp_trst_n = 1'b0;
        step(1'b0, 1'b0);
        bp_trst_n = 1'b1;
        step(1'b0, 1'b0);
        ir_scan({2'b00, MY_ADDR}, seen, drove);
        ir_scan(SEL_OP, seen, drove);
        dr_scan(4'b0001);
        check("R6 single-port select", lp_tms, 4'b1110);
        bp_trst_n = 1'b0;
        step(1'b0, 1'b0);
        check("R1 async clear lp_tms", lp_tms, 4'hF);
        check("R1 async clear bp_tri", bp_tri, 1);
        check("R9 lp_trst_n follows", lp_trst_n, 4'h0);
        bp_trst_n = 1'b1;
        step(1'b0, 1'b0);
        check("R9 lp_tck follows", lp_tck, {N{bp_tck}});

        // R10: float control
        lp_float = 1'b1;
        step(1'b0, 1'b0);
        check("R10 float high", lp_ctl_hiz, 1);
        lp_float = 1'b0;
        step(1'b0, 1'b0);
        check("R10 float low", lp_ctl_hiz, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule